// File: doc/BRIEF.md
# Power Domain Sequencer

This block switches a set of on-chip power domains on and off. One request names a domain and a direction. The block then walks that domain's switch controls in a fixed order. The controls are a sleep bit, a chain of memory-bank power-down fields, a reset bus, an isolation bit and a clock-enable bus. A programmable settling wait follows every step. Only one request runs at a time. `busy` is high while a request runs, and `done` marks its end.

Domains are described entirely by parameters:
- the sleep/isolation bit each domain owns, or none for a memory-only domain;
- the cumulative end position of each domain's bank range on the memory bus;
- a mask naming the domains that own the reset and clock buses.

The defaults describe seven domains:

| Index | Domain | Banks | Sleep/isolation bit |
|---|---|---|---|
| 0 | video | 8 | 8 |
| 1 | neural accelerator | 4 | 16 |
| 2 | USB | 1 | 17 |
| 3 | PCIe | 2 | 18 |
| 4 | 2D engine | 4 | 19 |
| 5 | audio | 6 | none (memory only) |
| 6 | Ethernet | 1 | none (memory only) |

Only the video domain owns the 11 resets and the 2 clocks.

States:
- `PS_IDLE`: waits for a request.
- `PS_SLEEP`, `PS_MEM`, `PS_RST_HOLD`, `PS_ISO`, `PS_RST_FREE`, `PS_CLK`: one action each.
- `PS_WAIT`: the settling count.
- `PS_FIN`: the done cycle.

Transitions:
- IDLE to the first step when a request is accepted. The first step is SLEEP, or MEM for a memory-only domain.
- IDLE to FIN when the request matches the domain's present state.
- Each step goes to WAIT when the latched wait is non-zero, or else straight to the next step.
- WAIT to the saved next step when the count expires.
- MEM loops on itself until the domain's last bank.
- The step after MEM for power-up is RST_HOLD, ISO, RST_FREE, CLK, skipping what the domain lacks.
- The step after MEM for power-down is ISO, CLK, skipping what the domain lacks.
- The last step goes to FIN, and FIN goes to IDLE.

Top module: `pds_seq_top`

## Requirements
- R1: After reset every domain is off:
  - sleep and isolation bits of all top-level domains are set, with all other bits of both words zero (default 0x000F0100);
  - every memory field is all ones;
  - `rst_bus` is all ones and `clk_en` is zero;
  - `dom_status` is all ones;
  - `busy`, `done` and `reject` are low.
- R2: Power-up runs these steps in order: clear sleep, clear each bank field, assert all resets, clear isolation, release all resets, enable all clocks.
- R3: Power-down runs these steps in order: set sleep, set each bank field to all ones, set isolation, gate all clocks. The reset bus is left as it is.
- R4: Each memory step changes exactly one BANK_W-bit field. Fields are visited from the lowest bank of the domain upward. Domain d owns the banks from DOM_BANK_END[d-1] (0 for d=0) up to DOM_BANK_END[d]-1, and bank b sits at bits [b*BANK_W +: BANK_W].
- R5: A request is sampled at a clock edge while idle, and the first step's effect appears after the next edge. Each step takes one cycle plus `wait_cycles` wait cycles, with the value latched at acceptance. For N steps, `done` is high in the cycle that starts N*(1+wait) edges after the accepting edge.
- R6: Memory-only domains never touch the sleep or isolation words. Their `dom_status` bit is 1 when off and changes at the edge that ends the done cycle.
- R7: Reset and clock steps occur only for domains flagged in DOM_OWNS_RC. The clock enable rises only after the resets are released.
- R8: For a domain with a sleep bit, `dom_status` equals that bit.
- R9: A request with an ID of N_DOM or above is rejected. `reject` is high for the following cycle, `busy` stays low, and no control output changes.
- R10: A request made while `busy` is high is ignored.
- R11: `done` is high for exactly one cycle, and `busy` is high during it. `busy` is high from the cycle after acceptance through the done cycle.
- R12: A request that matches the domain's present state goes straight to the done cycle on the next edge and changes no control output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_dom | input | ID_W | Target domain index |
| req_on | input | 1 | 1 = power up, 0 = power down |
| wait_cycles | input | WAIT_W | Settling cycles after each step |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| reject | output | 1 | One-cycle pulse for an out-of-range ID |
| sleep_word | output | CTRL_W | Sleep control bits |
| iso_word | output | CTRL_W | Isolation control bits |
| mem_pd | output | MEM_W | Bank power-down fields (1 = down) |
| rst_bus | output | N_RST | Domain resets, 1 = asserted |
| clk_en | output | N_CLK | Domain clock enables |
| dom_status | output | N_DOM | Per-domain off indication |

## Verification
The bench builds the block with the default seven-domain table and WAIT_W of 4. It drives `wait_cycles` at 0, 1, 2 and 3, so both back-to-back steps and the WAIT state are exercised, and latency can be measured against the step count. The 3-bit ID reaches index 7, which makes the rejection path reachable. The mix of domains covers the full video sequence with resets and clocks, memory-only domains, a single-bank domain and requests that match the present state.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [3:0] {
        PS_IDLE,
        PS_SLEEP,
        PS_MEM,
        PS_RST_HOLD,
        PS_ISO,
        PS_RST_FREE,
        PS_CLK,
        PS_WAIT,
        PS_FIN
    } pds_state_e;

    // One strobe per kind of action applied to the control registers
    typedef struct packed {
        logic sleep;
        logic mem;
        logic rst_hold;
        logic iso;
        logic rst_free;
        logic clk;
        logic commit;
    } pds_act_t;

endpackage

// File: rtl/pds_route.sv
module pds_route
    import pds_pkg::*;
(
    input  pds_state_e cur,
    input  logic       has_top,
    input  logic       has_rc,
    input  logic       last_bank,
    input  logic       dir_on,
    output pds_state_e nxt,
    output logic       bank_step
);

    always_comb begin
        nxt       = PS_FIN;
        bank_step = 1'b0;
        unique case (cur)
            PS_SLEEP: nxt = PS_MEM;
            PS_MEM: begin
                if (!last_bank) begin
                    nxt       = PS_MEM;
                    bank_step = 1'b1;
                end else if (dir_on) begin
                    nxt = has_rc ? PS_RST_HOLD : (has_top ? PS_ISO : PS_FIN);
                end else begin
                    nxt = has_top ? PS_ISO : (has_rc ? PS_CLK : PS_FIN);
                end
            end
            PS_RST_HOLD: nxt = has_top ? PS_ISO : PS_RST_FREE;
            PS_ISO: begin
                if (has_rc) nxt = dir_on ? PS_RST_FREE : PS_CLK;
                else        nxt = PS_FIN;
            end
            PS_RST_FREE: nxt = PS_CLK;
            PS_CLK:      nxt = PS_FIN;
            default:     nxt = PS_FIN;
        endcase
    end

endmodule

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    output logic              expire
);

    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == WAIT_W'(1));

endmodule

// File: rtl/pds_ctrl_regs.sv
module pds_ctrl_regs
    import pds_pkg::*;
#(
    parameter int N_DOM              = 7,
    parameter int ID_W               = 3,
    parameter int CTRL_W             = 32,
    parameter int TB_W               = 5,
    parameter int BANK_W             = 2,
    parameter int N_BANK             = 26,
    parameter int BIDX_W             = 5,
    parameter int N_RST              = 11,
    parameter int N_CLK              = 2,
    parameter int DOM_TOP_BIT [N_DOM] = '{8, 16, 17, 18, 19, -1, -1}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  pds_act_t                  act,
    input  logic                      set_val,
    input  logic [ID_W-1:0]           dom,
    input  logic [TB_W-1:0]           top_bit,
    input  logic [BIDX_W-1:0]         bank_idx,
    output logic [CTRL_W-1:0]         sleep_q,
    output logic [CTRL_W-1:0]         iso_q,
    output logic [N_BANK*BANK_W-1:0]  mem_q,
    output logic [N_RST-1:0]          rst_q,
    output logic [N_CLK-1:0]          clk_q,
    output logic [N_DOM-1:0]          off_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_q <= '0;
            iso_q   <= '0;
            for (int d = 0; d < N_DOM; d++) begin
                if (DOM_TOP_BIT[d] >= 0) begin
                    sleep_q[DOM_TOP_BIT[d]] <= 1'b1;
                    iso_q[DOM_TOP_BIT[d]]   <= 1'b1;
                end
            end
        end else begin
            if (act.sleep) sleep_q[top_bit] <= set_val;
            if (act.iso)   iso_q[top_bit]   <= set_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '1;
        end else if (act.mem) begin
            for (int b = 0; b < N_BANK; b++) begin
                if (bank_idx == BIDX_W'(b)) begin
                    mem_q[b*BANK_W +: BANK_W] <= {BANK_W{set_val}};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q <= '1;
            clk_q <= '0;
        end else begin
            if (act.rst_hold) rst_q <= '1;
            if (act.rst_free) rst_q <= '0;
            if (act.clk)      clk_q <= {N_CLK{~set_val}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '1;
        end else if (act.commit) begin
            for (int d = 0; d < N_DOM; d++) begin
                if (dom == ID_W'(d)) off_q[d] <= set_val;
            end
        end
    end

endmodule

// File: rtl/pds_seq_top.sv
module pds_seq_top
    import pds_pkg::*;
#(
    parameter int          N_DOM                = 7,
    parameter int          ID_W                 = 3,
    parameter int          CTRL_W               = 32,
    parameter int          BANK_W               = 2,
    parameter int          N_RST                = 11,
    parameter int          N_CLK                = 2,
    parameter int          WAIT_W               = 8,
    parameter int          DOM_TOP_BIT  [N_DOM] = '{8, 16, 17, 18, 19, -1, -1},
    parameter int          DOM_BANK_END [N_DOM] = '{8, 12, 13, 15, 19, 25, 26},
    parameter logic [N_DOM-1:0] DOM_OWNS_RC     = 7'b0000001,
    localparam int         N_BANK               = DOM_BANK_END[N_DOM-1],
    localparam int         MEM_W                = N_BANK * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_dom,
    input  logic              req_on,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              busy,
    output logic              done,
    output logic              reject,
    output logic [CTRL_W-1:0] sleep_word,
    output logic [CTRL_W-1:0] iso_word,
    output logic [MEM_W-1:0]  mem_pd,
    output logic [N_RST-1:0]  rst_bus,
    output logic [N_CLK-1:0]  clk_en,
    output logic [N_DOM-1:0]  dom_status
);

    localparam int TB_W   = $clog2(CTRL_W);
    localparam int BIDX_W = $clog2(N_BANK + 1);
    localparam logic [ID_W:0] DOM_LIMIT = (ID_W + 1)'(N_DOM);

    pds_state_e        state_q, ret_q, nxt_step;
    logic [ID_W-1:0]   dom_q;
    logic              on_q;
    logic [BIDX_W-1:0] bank_q;
    logic [WAIT_W-1:0] wait_q;
    logic              reject_q;

    logic              cur_top, cur_rc;
    logic [TB_W-1:0]   cur_tbit;
    logic [BIDX_W-1:0] cur_last;
    logic              req_top, req_off;
    logic [BIDX_W-1:0] req_first;
    logic              req_in_range, req_match;
    logic              bank_step, tmr_expire, is_step;
    pds_act_t          act;
    logic [N_DOM-1:0]  off_q;

    // Per-domain table lookups for the running and the requested domain
    always_comb begin
        int base;
        base      = 0;
        cur_top   = 1'b0;
        cur_rc    = 1'b0;
        cur_tbit  = '0;
        cur_last  = '0;
        req_top   = 1'b0;
        req_off   = 1'b0;
        req_first = '0;
        for (int d = 0; d < N_DOM; d++) begin
            if (dom_q == ID_W'(d)) begin
                cur_top  = (DOM_TOP_BIT[d] >= 0);
                cur_rc   = DOM_OWNS_RC[d];
                cur_tbit = TB_W'(DOM_TOP_BIT[d]);
                cur_last = BIDX_W'(DOM_BANK_END[d] - 1);
            end
            if (req_dom == ID_W'(d)) begin
                req_top   = (DOM_TOP_BIT[d] >= 0);
                req_off   = off_q[d];
                req_first = BIDX_W'(base);
            end
            base = DOM_BANK_END[d];
        end
    end

    assign req_in_range = ({1'b0, req_dom} < DOM_LIMIT);
    assign req_match    = (req_off == ~req_on);

    pds_route u_route (
        .cur       (state_q),
        .has_top   (cur_top),
        .has_rc    (cur_rc),
        .last_bank (bank_q == cur_last),
        .dir_on    (on_q),
        .nxt       (nxt_step),
        .bank_step (bank_step)
    );

    pds_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (is_step && (wait_q != '0)),
        .load_val (wait_q),
        .run      (state_q == PS_WAIT),
        .expire   (tmr_expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            ret_q    <= PS_IDLE;
            dom_q    <= '0;
            on_q     <= 1'b0;
            bank_q   <= '0;
            wait_q   <= '0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= 1'b0;
            unique case (state_q)
                PS_IDLE: begin
                    if (req_valid) begin
                        if (!req_in_range) begin
                            reject_q <= 1'b1;
                        end else begin
                            dom_q  <= req_dom;
                            on_q   <= req_on;
                            bank_q <= req_first;
                            wait_q <= wait_cycles;
                            if (req_match)    state_q <= PS_FIN;
                            else if (req_top) state_q <= PS_SLEEP;
                            else              state_q <= PS_MEM;
                        end
                    end
                end
                PS_WAIT: begin
                    if (tmr_expire) state_q <= ret_q;
                end
                PS_FIN: state_q <= PS_IDLE;
                default: begin
                    if (bank_step) bank_q <= bank_q + 1'b1;
                    if (wait_q != '0) begin
                        state_q <= PS_WAIT;
                        ret_q   <= nxt_step;
                    end else begin
                        state_q <= nxt_step;
                    end
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        act     = '0;
        is_step = 1'b0;
        busy    = (state_q != PS_IDLE);
        done    = (state_q == PS_FIN);
        unique case (state_q)
            PS_SLEEP:    begin act.sleep    = 1'b1; is_step = 1'b1; end
            PS_MEM:      begin act.mem      = 1'b1; is_step = 1'b1; end
            PS_RST_HOLD: begin act.rst_hold = 1'b1; is_step = 1'b1; end
            PS_ISO:      begin act.iso      = 1'b1; is_step = 1'b1; end
            PS_RST_FREE: begin act.rst_free = 1'b1; is_step = 1'b1; end
            PS_CLK:      begin act.clk      = 1'b1; is_step = 1'b1; end
            PS_FIN:      act.commit = 1'b1;
            default:     ;
        endcase
    end

    assign reject = reject_q;

    pds_ctrl_regs #(
        .N_DOM       (N_DOM),
        .ID_W        (ID_W),
        .CTRL_W      (CTRL_W),
        .TB_W        (TB_W),
        .BANK_W      (BANK_W),
        .N_BANK      (N_BANK),
        .BIDX_W      (BIDX_W),
        .N_RST       (N_RST),
        .N_CLK       (N_CLK),
        .DOM_TOP_BIT (DOM_TOP_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .set_val  (~on_q),
        .dom      (dom_q),
        .top_bit  (cur_tbit),
        .bank_idx (bank_q),
        .sleep_q  (sleep_word),
        .iso_q    (iso_word),
        .mem_q    (mem_pd),
        .rst_q    (rst_bus),
        .clk_q    (clk_en),
        .off_q    (off_q)
    );

    for (genvar d = 0; d < N_DOM; d++) begin : g_status
        if (DOM_TOP_BIT[d] >= 0) begin : g_top
            assign dom_status[d] = sleep_word[DOM_TOP_BIT[d]];
        end else begin : g_memonly
            assign dom_status[d] = off_q[d];
        end
    end

endmodule

// File: rtl/pds_seq_chk.sv
module pds_seq_chk #(
    parameter int CTRL_W = 32,
    parameter int MEM_W  = 52,
    parameter int BANK_W = 2,
    parameter int N_RST  = 11,
    parameter int N_CLK  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              reject,
    input logic [CTRL_W-1:0] sleep_word,
    input logic [CTRL_W-1:0] iso_word,
    input logic [MEM_W-1:0]  mem_pd,
    input logic [N_RST-1:0]  rst_bus,
    input logic [N_CLK-1:0]  clk_en
);

    localparam int N_FIELD = MEM_W / BANK_W;

    logic [MEM_W-1:0]   mem_d;
    logic [N_FIELD-1:0] fld_chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_d <= '1;
        else        mem_d <= mem_pd;
    end

    always_comb begin
        for (int f = 0; f < N_FIELD; f++) begin
            fld_chg[f] = (mem_d[f*BANK_W +: BANK_W] != mem_pd[f*BANK_W +: BANK_W]);
        end
    end

    AST_ONE_FIELD_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fld_chg) <= 1) else $error("memory fields changed together"); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R11

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy) else $error("done without busy"); // R11

    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !busy) else $error("reject while busy"); // R10

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> ($stable(sleep_word) && $stable(iso_word) && $stable(mem_pd)
                    && $stable(rst_bus) && $stable(clk_en))) else $error("reject moved outputs"); // R9

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({sleep_word, iso_word, mem_pd}) |-> $past(busy)) else $error("control moved while idle"); // R9

    AST_CLK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en[0]) |-> (rst_bus == '0)) else $error("clock on with resets held"); // R7

endmodule

bind pds_seq_top pds_seq_chk #(
    .CTRL_W (CTRL_W),
    .MEM_W  (MEM_W),
    .BANK_W (BANK_W),
    .N_RST  (N_RST),
    .N_CLK  (N_CLK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .reject     (reject),
    .sleep_word (sleep_word),
    .iso_word   (iso_word),
    .mem_pd     (mem_pd),
    .rst_bus    (rst_bus),
    .clk_en     (clk_en)
);

// File: tb/pds_seq_top_tb.sv
module pds_seq_top_tb;

    localparam int N_DOM  = 7;
    localparam int ID_W   = 3;
    localparam int CTRL_W = 32;
    localparam int BANK_W = 2;
    localparam int N_RST  = 11;
    localparam int N_CLK  = 2;
    localparam int WAIT_W = 4;
    localparam int TOPB [N_DOM] = '{8, 16, 17, 18, 19, -1, -1};
    localparam int BEND [N_DOM] = '{8, 12, 13, 15, 19, 25, 26};
    localparam logic [N_DOM-1:0] RC = 7'b0000001;
    localparam int MEM_W = 26 * BANK_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              req_valid = 1'b0;
    logic [ID_W-1:0]   req_dom = '0;
    logic              req_on = 1'b0;
    logic [WAIT_W-1:0] wait_cycles = '0;
    logic              busy, done, reject;
    logic [CTRL_W-1:0] sleep_word, iso_word;
    logic [MEM_W-1:0]  mem_pd;
    logic [N_RST-1:0]  rst_bus;
    logic [N_CLK-1:0]  clk_en;
    logic [N_DOM-1:0]  dom_status;

    pds_seq_top #(
        .N_DOM(N_DOM), .ID_W(ID_W), .CTRL_W(CTRL_W), .BANK_W(BANK_W),
        .N_RST(N_RST), .N_CLK(N_CLK), .WAIT_W(WAIT_W),
        .DOM_TOP_BIT(TOPB), .DOM_BANK_END(BEND), .DOM_OWNS_RC(RC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dom(req_dom),
        .req_on(req_on), .wait_cycles(wait_cycles), .busy(busy), .done(done),
        .reject(reject), .sleep_word(sleep_word), .iso_word(iso_word),
        .mem_pd(mem_pd), .rst_bus(rst_bus), .clk_en(clk_en), .dom_status(dom_status)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [CTRL_W-1:0] e_sleep, e_iso;
    logic [MEM_W-1:0]  e_mem;
    logic [N_RST-1:0]  e_rst;
    logic [N_CLK-1:0]  e_clk;
    logic [N_DOM-1:0]  e_off;
    logic              e_reject;
    int  m_phase;   // 0 idle, 1 running, 2 done cycle
    int  m_cnt, m_w, m_dom;
    bit  m_on;
    int  m_q[$];

    function automatic void m_reset();
        e_sleep = '0; e_iso = '0;
        for (int d = 0; d < N_DOM; d++) if (TOPB[d] >= 0) begin
            e_sleep[TOPB[d]] = 1'b1; e_iso[TOPB[d]] = 1'b1;
        end
        e_mem = '1; e_rst = '1; e_clk = '0; e_off = '1; e_reject = 1'b0;
        m_phase = 0; m_cnt = 0; m_w = 0; m_dom = 0; m_on = 1'b0;
        m_q.delete();
    endfunction

    function automatic void m_apply(input int code);
        int  kind;
        int  arg;
        logic v;
        kind = code / 1000;
        arg  = code % 1000;
        v    = !m_on;
        case (kind)
            1: e_sleep[TOPB[m_dom]] = v;
            2: e_mem[arg*BANK_W +: BANK_W] = {BANK_W{v}};
            3: e_rst = '1;
            4: e_iso[TOPB[m_dom]] = v;
            5: e_rst = '0;
            6: e_clk = {N_CLK{!v}};
            default: ;
        endcase
    endfunction

    function automatic void m_tick();
        e_reject = 1'b0;
        case (m_phase)
            2: begin
                e_off[m_dom] = !m_on;
                m_phase = 0;
            end
            1: begin
                if (m_cnt == 0) begin
                    m_apply(m_q.pop_front());
                    m_cnt = m_w;
                end else begin
                    m_cnt--;
                end
                if (m_cnt == 0 && m_q.size() == 0) m_phase = 2;
            end
            default: if (req_valid) begin
                if (int'(req_dom) >= N_DOM) begin
                    e_reject = 1'b1;
                end else begin
                    int base;
                    m_dom = int'(req_dom); m_on = req_on; m_w = int'(wait_cycles);
                    if (e_off[m_dom] == !m_on) begin
                        m_phase = 2;
                    end else begin
                        base = 0;
                        for (int d = 0; d < m_dom; d++) base = BEND[d];
                        if (TOPB[m_dom] >= 0) m_q.push_back(1000);
                        for (int b = base; b < BEND[m_dom]; b++) m_q.push_back(2000 + b);
                        if (m_on) begin
                            if (RC[m_dom]) m_q.push_back(3000);
                            if (TOPB[m_dom] >= 0) m_q.push_back(4000);
                            if (RC[m_dom]) begin m_q.push_back(5000); m_q.push_back(6000); end
                        end else begin
                            if (TOPB[m_dom] >= 0) m_q.push_back(4000);
                            if (RC[m_dom]) m_q.push_back(6000);
                        end
                        m_cnt = 0;
                        m_phase = 1;
                    end
                end
            end
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else        m_tick();
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [N_DOM-1:0] e_stat;
            for (int d = 0; d < N_DOM; d++)
                e_stat[d] = (TOPB[d] >= 0) ? e_sleep[TOPB[d]] : e_off[d];
            chk("R2 sleep_word", 64'(sleep_word), 64'(e_sleep));
            chk("R3 iso_word",   64'(iso_word),   64'(e_iso));
            chk("R4 mem_pd",     64'(mem_pd),     64'(e_mem));
            chk("R7 rst_bus",    64'(rst_bus),    64'(e_rst));
            chk("R7 clk_en",     64'(clk_en),     64'(e_clk));
            chk("R8 dom_status", 64'(dom_status), 64'(e_stat));
            chk("R10 busy",      64'(busy),       64'(m_phase != 0));
            chk("R11 done",      64'(done),       64'(m_phase == 2));
            chk("R9 reject",     64'(reject),     64'(e_reject));
        end
    end

    // ---------------- stimulus ----------------
    function automatic int n_steps(input int d, input bit on);
        int base;
        base = (d == 0) ? 0 : BEND[d-1];
        return ((TOPB[d] >= 0) ? 2 : 0) + (BEND[d] - base) + (RC[d] ? (on ? 3 : 1) : 0);
    endfunction

    task automatic issue(input int id, input bit on, input int w, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_dom = ID_W'(id); req_on = on; wait_cycles = WAIT_W'(w);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int lat;
        logic [CTRL_W-1:0] snap_s, snap_i;
        logic [MEM_W-1:0]  snap_m;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sleep reset",  64'(sleep_word), 64'h000F_0100);
        chk("R1 iso reset",    64'(iso_word),   64'h000F_0100);
        chk("R1 mem reset",    64'(mem_pd),     {12'h0, {MEM_W{1'b1}}});
        chk("R1 rst reset",    64'(rst_bus),    64'h7FF);
        chk("R1 clk reset",    64'(clk_en),     64'h0);
        chk("R1 status reset", 64'(dom_status), 64'h7F);
        chk("R1 busy reset",   64'(busy),       64'h0);

        // Video up, no wait: full sequence with resets and clocks
        issue(0, 1'b1, 0, lat);
        chk("R5 video up latency", 64'(lat), 64'(n_steps(0, 1'b1) * 1 + 1));
        chk("R7 video clocks on",  64'(clk_en), 64'h3);
        chk("R7 video resets off", 64'(rst_bus), 64'h0);
        chk("R8 video status",     64'(dom_status[0]), 64'h0);
        chk("R2 video iso clear",  64'(iso_word[8]), 64'h0);

        // Video down, wait 2
        issue(0, 1'b0, 2, lat);
        chk("R5 video down latency", 64'(lat), 64'(n_steps(0, 1'b0) * 3 + 1));
        chk("R3 video sleep set",    64'(sleep_word[8]), 64'h1);
        chk("R3 video iso set",      64'(iso_word[8]), 64'h1);
        chk("R3 video clocks off",   64'(clk_en), 64'h0);
        chk("R3 resets untouched",   64'(rst_bus), 64'h0);
        chk("R4 video banks down",   64'(mem_pd[15:0]), 64'hFFFF);

        // Audio (memory only) up, wait 1
        snap_s = sleep_word; snap_i = iso_word;
        issue(5, 1'b1, 1, lat);
        chk("R5 audio latency",      64'(lat), 64'(n_steps(5, 1'b1) * 2 + 1));
        chk("R6 audio sleep intact", 64'(sleep_word), 64'(snap_s));
        chk("R6 audio iso intact",   64'(iso_word), 64'(snap_i));
        chk("R4 audio banks up",     64'(mem_pd[49:38]), 64'h0);
        chk("R6 audio status",       64'(dom_status[5]), 64'h0);

        // Matching request: audio already on
        snap_m = mem_pd;
        issue(5, 1'b1, 3, lat);
        chk("R12 match latency", 64'(lat), 64'h1);
        chk("R12 match mem",     64'(mem_pd), 64'(snap_m));

        // Neural accelerator up with wait 3; USB request while busy is refused
        @(negedge clk);
        req_valid = 1'b1; req_dom = 3'd1; req_on = 1'b1; wait_cycles = 4'd3;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_dom = 3'd2; req_on = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R10 usb stays off",    64'(dom_status[2]), 64'h1);
        chk("R10 usb sleep set",    64'(sleep_word[17]), 64'h1);
        chk("R7 nna leaves clocks", 64'(clk_en), 64'h0);
        chk("R8 nna status",        64'(dom_status[1]), 64'h0);

        // Out-of-range ID
        snap_s = sleep_word; snap_m = mem_pd;
        @(negedge clk);
        req_valid = 1'b1; req_dom = 3'd7; req_on = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 reject pulse", 64'(reject), 64'h1);
        chk("R9 reject busy",  64'(busy), 64'h0);
        chk("R9 reject sleep", 64'(sleep_word), 64'(snap_s));
        chk("R9 reject mem",   64'(mem_pd), 64'(snap_m));
        @(negedge clk);

        // Ethernet single bank, 2D engine already off, PCIe up, video up
        issue(6, 1'b1, 0, lat);
        chk("R5 eth latency", 64'(lat), 64'(n_steps(6, 1'b1) + 1));
        chk("R4 eth bank",    64'(mem_pd[51:50]), 64'h0);
        issue(4, 1'b0, 2, lat);
        chk("R12 ge2d match", 64'(lat), 64'h1);
        issue(3, 1'b1, 1, lat);
        chk("R5 pcie latency", 64'(lat), 64'(n_steps(3, 1'b1) * 2 + 1));
        issue(0, 1'b1, 1, lat);
        chk("R5 video up wait", 64'(lat), 64'(n_steps(0, 1'b1) * 2 + 1));
        chk("R7 video clocks",  64'(clk_en), 64'h3);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule